// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the system clock. Two programmed counts set the timing. The half-period count sets how many system cycles the line is held low. It is also the nominal number of cycles the line stays released. The rise allowance is the worst-case delay from the moment the block releases the line until that release can show up on the sampled SCL input. That delay covers bus rise time, input filtering and synchronization. The SCL input reaching the block is assumed to be synchronized to the system clock already.

The high phase is timed from the cycle in which the line is released. The block does not look at the SCL input until the rise allowance has run out. From then on, a low input means a slave is stretching the clock. While that lasts, the high-phase count is frozen, and it resumes once the line reads high. A slow but unstretched bus therefore does not change the clock period, and a stretched bus still gets its full minimum high time.

The output is an active-high pull-down request: the block asks for SCL to be pulled low during the low phase and leaves it released otherwise. Single-cycle strobes mark the start of each phase the block creates.

Top module: `scl_clkgen`

## Requirements
- R1: While enable is low (and during reset), scl_drive_low, scl_rise and scl_fall are all 0.
- R2: In the cycle after enable is first seen high, scl_fall pulses and scl_drive_low becomes 1, so operation always starts with a low phase.
- R3: Each low phase lasts max(half_cnt, 1) cycles of scl_drive_low = 1.
- R4: With SCL read high whenever it is sampled, each high phase lasts H = max(half_cnt, rise_allow + 1) cycles. A half count at or below the rise allowance is therefore raised to rise_allow + 1.
- R5: During the first rise_allow cycles of a high phase, the SCL input is ignored. A low level there neither lengthens nor shortens the phase.
- R6: Counting cycles from the release, with cycle index k starting at 0, a low SCL input in any cycle k ≥ rise_allow freezes the high count for that cycle. The high phase is lengthened by exactly the number of frozen cycles.
- R7: scl_rise is a one-cycle pulse in the first released cycle of a high phase. scl_fall is a one-cycle pulse in the first cycle of a low phase. The two never pulse in the same cycle.
- R8: half_cnt and rise_allow are captured when operation starts. Changing them while enabled has no effect until the next start.
- R9: Dropping enable in the middle of a phase releases the line in the next cycle. The next enable then starts again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the clock generator |
| half_cnt | input | CW | Low-phase length and nominal high-phase length, in cycles |
| rise_allow | input | CW | Cycles after release before the SCL input is sampled |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_drive_low | output | 1 | 1 requests SCL to be pulled low |
| scl_rise | output | 1 | Pulse at the start of a high phase |
| scl_fall | output | 1 | Pulse at the start of a low phase |

## Verification
The delicate overlap is between the first sampling point of the SCL input and the last count of the high phase. This happens when the half count is at or below the rise allowance, so the clamped phase reaches its final count in the very cycle the input is first examined. The bench programs half_cnt = 2 and rise_allow = 4, then makes the simulated bus show its high level one cycle after that final count. It expects the high phase to last six cycles rather than five. An unstretched run with the same settings must give five. A second overlap, where enable drops in the same cycle a phase would roll over, is covered by comparing every cycle against the behavioural model.

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half_cnt,
  input  logic [CW-1:0] rise_allow,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          scl_rise,
  output logic          scl_fall
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} ph_t;

  ph_t         ph;
  logic [CW:0] cnt;
  logic [CW:0] lo_q, hi_q;
  logic [CW:0] tr_q;
  logic        rise_q, fall_q;

  wire [CW:0] half_w = {1'b0, half_cnt};
  wire [CW:0] tr_w   = {1'b0, rise_allow};
  wire [CW:0] lo_n   = (half_cnt == '0) ? {{CW{1'b0}}, 1'b1} : half_w;
  wire [CW:0] hi_n   = (half_w > tr_w) ? half_w : tr_w + 1'b1;

  wire win_open = (cnt >= tr_q);
  wire adv      = (ph == S_LOW) | ~win_open | scl_in;
  wire last     = (ph == S_LOW) ? (cnt == lo_q - 1'b1) : (cnt == hi_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      cnt    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      tr_q   <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!en) begin
      ph     <= S_IDLE;
      cnt    <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      case (ph)
        S_IDLE: begin
          lo_q   <= lo_n;
          hi_q   <= hi_n;
          tr_q   <= tr_w;
          cnt    <= '0;
          ph     <= S_LOW;
          fall_q <= 1'b1;
        end
        S_LOW, S_HIGH: begin
          if (adv) begin
            if (last) begin
              cnt    <= '0;
              ph     <= (ph == S_LOW) ? S_HIGH : S_LOW;
              rise_q <= (ph == S_LOW);
              fall_q <= (ph == S_HIGH);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (ph == S_LOW);
  assign scl_rise      = rise_q;
  assign scl_fall      = fall_q;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int CW = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        scl_in,
  input logic        scl_drive_low,
  input logic        scl_rise,
  input logic        scl_fall,
  input logic [1:0]  ph,
  input logic [CW:0] cnt,
  input logic [CW:0] tr_q
);
  a_r7_no_double_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !scl_rise && !scl_fall));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(!en)) |=> (scl_fall && scl_drive_low));

  a_r7_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (scl_drive_low && !$past(scl_drive_low)));

  a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (!scl_drive_low && $past(scl_drive_low)));

  a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph == 2'd2 && cnt >= tr_q && !scl_in) |=> ($stable(cnt) && !scl_drive_low));
endmodule

bind scl_clkgen scl_clkgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .ph(ph), .cnt(cnt), .tr_q(tr_q)
);

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0, en = 0, scl_in = 0;
  logic [CW-1:0] ccr = '0, trise = '0;
  logic drv, rise, fall;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clkgen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .half_cnt(ccr), .rise_allow(trise),
    .scl_in(scl_in), .scl_drive_low(drv), .scl_rise(rise), .scl_fall(fall)
  );

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 low, 2 high
  int m_ph = 0, m_n = 0, m_lo = 1, m_hi = 1, m_tr = 0;
  bit m_r = 0, m_f = 0;

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_ph = 0; m_n = 0; m_r = 0; m_f = 0;
    end else begin
      m_r = 0; m_f = 0;
      if (m_ph == 0) begin
        m_lo = (int'(ccr) == 0) ? 1 : int'(ccr);
        m_tr = int'(trise);
        m_hi = (int'(ccr) > int'(trise)) ? int'(ccr) : int'(trise) + 1;
        m_ph = 1; m_n = 0; m_f = 1;
      end else if (m_ph == 1) begin
        m_n++;
        if (m_n == m_lo) begin m_ph = 2; m_n = 0; m_r = 1; end
      end else begin
        if (m_n < m_tr || scl_in) m_n++;
        if (m_n == m_hi) begin m_ph = 1; m_n = 0; m_f = 1; end
      end
    end
  end

  int bus_delay = 0, rel = 0;
  int run_hi = 0, run_lo = 0, last_hi = 0, last_lo = 0;

  always @(negedge clk) begin
    checks++;
    if (drv !== (m_ph == 1) || rise !== m_r || fall !== m_f) begin
      errors++;
      $display("FAIL %s drive/rise/fall=%b%b%b expected %b%b%b", tag, drv, rise, fall,
               (m_ph == 1), m_r, m_f);
    end
    if (drv) begin
      if (run_hi > 0) last_hi = run_hi;
      run_hi = 0; run_lo++;
    end else begin
      if (run_lo > 0) last_lo = run_lo;
      run_lo = 0; run_hi++;
    end
    if (drv) begin rel = 0; scl_in = 0; end
    else begin scl_in = (rel >= bus_delay); rel++; end
  end

  task automatic chk(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(int c, int t, int d);
    en = 0;
    run(3);
    #1 chk("R9 released while disabled", int'(drv), 0);
    ccr = c[CW-1:0]; trise = t[CW-1:0]; bus_delay = d;
    @(negedge clk); en = 1;
  endtask

  initial begin
    run(3);
    #1 chk("R1 reset drive", int'(drv), 0);
    chk("R1 reset pulses", int'(rise) + int'(fall), 0);
    rst_n = 1;
    run(4);
    #1 chk("R1 disabled drive", int'(drv), 0);

    tag = "R2";
    ccr = 5; trise = 2; bus_delay = 1;
    @(negedge clk); en = 1;
    @(negedge clk); #1;
    chk("R2 fall pulse at start", int'(fall), 1);
    chk("R2 drive low at start", int'(drv), 1);
    tag = "R3";
    run(40); #1;
    chk("R3 low length", last_lo, 5);
    chk("R4 high length", last_hi, 5);

    tag = "R5";
    start(6, 3, 2);
    run(50); #1;
    chk("R5 early low input ignored", last_hi, 6);
    chk("R3 low length ccr6", last_lo, 6);

    tag = "R6";
    start(5, 2, 5);
    run(60); #1;
    chk("R6 stretched high length", last_hi, 8);

    tag = "R4";
    start(2, 4, 0);
    run(40); #1;
    chk("R4 clamped high length", last_hi, 5);
    chk("R3 low length ccr2", last_lo, 2);

    tag = "R6";
    start(2, 4, 5);
    run(40); #1;
    chk("R6 stretch at final count", last_hi, 6);

    tag = "R3";
    start(0, 0, 0);
    run(20); #1;
    chk("R3 zero count low", last_lo, 1);
    chk("R4 zero count high", last_hi, 1);

    tag = "R8";
    start(5, 2, 0);
    run(20);
    ccr = 20; trise = 0;
    run(40); #1;
    chk("R8 low unchanged", last_lo, 5);
    chk("R8 high unchanged", last_hi, 5);

    tag = "R9";
    while (!rise) @(negedge clk);
    run(1);
    en = 0;
    @(negedge clk); #1;
    chk("R9 drop mid phase drive", int'(drv), 0);
    chk("R9 drop mid phase pulses", int'(rise) + int'(fall), 0);
    en = 1;
    @(negedge clk); #1;
    chk("R9 restart fall", int'(fall), 1);
    chk("R7 no rise with fall", int'(rise), 0);
    tag = "R7";
    run(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule